// File: doc/BRIEF.md
# Two-Lane Serial Converter Sample Deserializer

This block rebuilds parallel 14-bit converter samples from two serial lanes. The converter sends each sample as a 16-bit frame: eight bits on each lane, first bit first. A frame-clock rising edge marks where every frame begins. The bit clock and the frame clock reach the block as single-cycle strobes that are already aligned to the fabric clock. A rising-edge strobe and a falling-edge strobe stand for the two edges of the bit clock. A frame-clock strobe is valid only together with a rising bit strobe, and it marks that bit as the first bit of a new frame.

Two lane mappings are supported:
- **Interleaved:** the odd data bits travel on lane 1 and the even data bits on lane 0.
- **Split-halves:** the upper eight data bits travel on lane 1 and the lower six on lane 0.

Bits may arrive on rising bit-clock edges only (single rate) or on both edges (double rate). A sample is checked for length before it is released. It is output at the next frame boundary, and only if exactly eight bits arrived since the previous boundary. A frame of the wrong length is therefore discarded instead of being passed on corrupted.

Top module: `adc_lane_deser`

## Requirements
- R1: While reset is high, and after it, `valid_o` is 0 and `sample_o` is 0. Bits received before the first accepted frame start produce no output. The first frame start after reset produces no `valid_o`.
- R2: With `split_mode_i`=0 (interleaved), bit slot k (k=0..6, slot 0 first) carries D(13-2k) on lane 1 and D(12-2k) on lane 0. Slot 7 is padding on both lanes.
- R3: With `split_mode_i`=1 (split halves), lane 1 carries D13 down to D6 in slots 0..7. Lane 0 carries D5 down to D0 in slots 0..5, and slots 6 and 7 are padding.
- R4: The values on padding slots have no effect on `sample_o`.
- R5: With `dual_edge_i`=0, only `bit_rise_i` strobes capture bits. Lane values present on `bit_fall_i` strobes are ignored.
- R6: With `dual_edge_i`=1, both `bit_rise_i` and `bit_fall_i` strobes capture bits.
- R7: A frame of exactly eight captured bits yields `valid_o`=1 for one cycle, carrying the assembled sample. This happens in the cycle after the next accepted frame start (`frame_rise_i` and `bit_rise_i` both high). `valid_o` is 0 at all other times, and `sample_o` holds its value between valid pulses.
- R8: A frame with fewer than eight bits before the next frame start produces no `valid_o`.
- R9: A frame with more than eight bits before the next frame start produces no `valid_o`.
- R10: The mapping and rate inputs are sampled at the frame start and apply to the whole frame. Changes to them later in the frame have no effect on that frame.
- R11: A `frame_rise_i` strobe without `bit_rise_i` in the same cycle is ignored. It neither restarts nor ends a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| lane0_i | input | 1 | Serial lane 0 bit |
| lane1_i | input | 1 | Serial lane 1 bit |
| bit_rise_i | input | 1 | Strobe: rising bit-clock edge |
| bit_fall_i | input | 1 | Strobe: falling bit-clock edge |
| frame_rise_i | input | 1 | Strobe: rising frame-clock edge |
| split_mode_i | input | 1 | 0 interleaved mapping, 1 split-halves mapping |
| dual_edge_i | input | 1 | 0 single rate, 1 double rate |
| sample_o | output | 14 | Recovered sample |
| valid_o | output | 1 | One-cycle pulse for each good frame |

## Verification
The assertions assume the following about the inputs:
- `frame_rise_i` only matters when it coincides with `bit_rise_i`.
- Two frame starts are always separated by several bit strobes, so a valid pulse can never be followed directly by another.

The stimulus keeps within these limits. It spaces every strobe at least one fabric cycle apart and drives every frame with at least five bit slots. Stray frame strobes are placed only on cycles that carry no bit strobe.

// File: rtl/adc_lane_deser.sv
module adc_lane_deser #(
  parameter int SAMPLE_W   = 14,
  parameter int FRAME_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lane0_i,
  input  logic                lane1_i,
  input  logic                bit_rise_i,
  input  logic                bit_fall_i,
  input  logic                frame_rise_i,
  input  logic                split_mode_i,
  input  logic                dual_edge_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam int PAIRS = SAMPLE_W / 2;
  localparam int LO_W  = SAMPLE_W - FRAME_BITS;

  logic [FRAME_BITS-1:0] sr0, sr1;
  logic [CNT_W-1:0]      cnt;
  logic                  split_q, dual_q;
  logic [SAMPLE_W-1:0]   inter_w, halves_w;

  wire start = frame_rise_i & bit_rise_i;
  wire ev    = bit_rise_i | (bit_fall_i & dual_q);
  wire full  = (cnt == CNT_W'(FRAME_BITS));
  wire busy  = (cnt != '0) && (cnt <= CNT_W'(FRAME_BITS));

  for (genvar k = 0; k < PAIRS; k++) begin : g_inter
    assign inter_w[SAMPLE_W-1-2*k] = sr1[FRAME_BITS-1-k];
    assign inter_w[SAMPLE_W-2-2*k] = sr0[FRAME_BITS-1-k];
  end

  assign halves_w = {sr1, sr0[FRAME_BITS-1 -: LO_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr0      <= '0;
      sr1      <= '0;
      cnt      <= '0;
      split_q  <= 1'b0;
      dual_q   <= 1'b0;
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start) begin
        if (full) begin
          sample_o <= split_q ? halves_w : inter_w;
          valid_o  <= 1'b1;
        end
        split_q <= split_mode_i;
        dual_q  <= dual_edge_i;
        sr0     <= {sr0[FRAME_BITS-2:0], lane0_i};
        sr1     <= {sr1[FRAME_BITS-2:0], lane1_i};
        cnt     <= CNT_W'(1);
      end else if (ev && busy) begin
        sr0 <= {sr0[FRAME_BITS-2:0], lane0_i};
        sr1 <= {sr1[FRAME_BITS-2:0], lane1_i};
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

module adc_lane_deser_chk #(
  parameter int SAMPLE_W = 14
) (
  input logic                clk,
  input logic                rst,
  input logic                bit_rise_i,
  input logic                frame_rise_i,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                valid_o
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!valid_o && sample_o == '0));

  p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  p_valid_after_start_r11: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(frame_rise_i && bit_rise_i));

  p_sample_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !valid_o) |-> $stable(sample_o));
endmodule

bind adc_lane_deser adc_lane_deser_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .bit_rise_i(bit_rise_i), .frame_rise_i(frame_rise_i),
  .sample_o(sample_o), .valid_o(valid_o)
);

// File: tb/adc_lane_deser_bench.sv
module adc_lane_deser_bench;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1;
  logic lane0 = 0, lane1 = 0, rise = 0, fall = 0, fr = 0, split = 0, dual = 0;
  logic [13:0] sample;
  logic valid;
  int checks = 0, errors = 0;
  bit pend_v = 0;
  logic [13:0] pend_s = '0;
  string pend_tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  adc_lane_deser u_adc_lane_deser (
    .clk(clk), .rst(rst), .lane0_i(lane0), .lane1_i(lane1),
    .bit_rise_i(rise), .bit_fall_i(fall), .frame_rise_i(fr),
    .split_mode_i(split), .dual_edge_i(dual),
    .sample_o(sample), .valid_o(valid)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, f, s, l0, l1, bm, dm);
    @(negedge clk);
    rise = r; fall = f; fr = s; lane0 = l0; lane1 = l1; split = bm; dual = dm;
    @(posedge clk);
    #1;
  endtask

  task automatic slot(input logic [13:0] d, input bit bm, input int i, input bit pad1,
                      output logic l0, output logic l1);
    if (i >= 8) begin
      l0 = i[0]; l1 = ~i[0];
    end else if (!bm) begin
      l1 = (i < 7) ? d[13-2*i] : pad1;
      l0 = (i < 7) ? d[12-2*i] : pad1;
    end else begin
      l1 = d[13-i];
      l0 = (i < 6) ? d[5-i] : pad1;
    end
  endtask

  // R10: modes driven inverted after the frame start on every frame
  task automatic frame(input logic [13:0] d, input bit bm, input bit dm, input int nbits,
                       input bit pad1, input bit stray, input string tag);
    logic l0, l1;
    for (int i = 0; i < nbits; i++) begin
      bit first = (i == 0);
      logic mb = first ? bm : !bm;
      logic md = first ? dm : !dm;
      slot(d, bm, i, pad1, l0, l1);
      if (dm) step(i % 2 == 0, i % 2 == 1, first, l0, l1, mb, md);
      else    step(1, 0, first, l0, l1, mb, md);
      if (first) begin
        chk({pend_tag, " valid"}, 16'(valid), 16'(pend_v));
        if (pend_v) chk({pend_tag, " sample"}, 16'(sample), 16'(pend_s));
      end else begin
        chk("R7 no valid mid-frame", 16'(valid), 16'(0));
      end
      if (!dm) begin
        step(0, 1, 0, ~l0, ~l1, !bm, !dm);   // R5 fall strobe with wrong bits
        chk("R5 no valid on fall", 16'(valid), 16'(0));
      end
      if (stray && i == 3) begin
        step(0, 0, 1, ~l0, l1, !bm, !dm);    // R11 stray frame strobe
        chk("R11 stray frame strobe", 16'(valid), 16'(0));
      end
    end
    pend_v   = (nbits == 8);
    pend_s   = d;
    pend_tag = tag;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk("R1 reset valid", 16'(valid), 16'(0));
    chk("R1 reset sample", 16'(sample), 16'(0));
    rst = 0;
    for (int i = 0; i < 10; i++) begin
      step(1, 0, 0, 1, 1, 0, 0);
      step(0, 1, 0, 1, 1, 0, 0);
      chk("R1 no output before first frame", 16'(valid), 16'(0));
    end
    pend_tag = "R1 first frame";
    pend_v = 0;
    for (int bm = 0; bm < 2; bm++)
      for (int dm = 0; dm < 2; dm++) begin
        string tag = $sformatf("%s/%s/R10 bm%0d dm%0d", bm ? "R3" : "R2", dm ? "R6" : "R5", bm, dm);
        frame(14'h0000, bm[0], dm[0], 8, 0, 0, tag);
        frame(14'h3FFF, bm[0], dm[0], 8, 0, 0, tag);
        frame(14'h2AAA, bm[0], dm[0], 8, 0, 0, tag);
        frame(14'h1555, bm[0], dm[0], 8, 0, 0, tag);
        for (int b = 0; b < 14; b++) frame(14'(1 << b), bm[0], dm[0], 8, 0, 0, tag);
        for (int b = 0; b < 14; b++) frame(~14'(1 << b), bm[0], dm[0], 8, 0, 0, tag);
        frame(14'h0000, bm[0], dm[0], 8, 1, 0, "R4 padding ones");
        frame(14'h1234, bm[0], dm[0], 8, 1, 0, "R4 padding ones");
        frame(14'h2C3A, bm[0], dm[0], 5, 0, 0, "R8 short frame");
        frame(14'h0F0F, bm[0], dm[0], 7, 0, 0, "R8 short frame");
        frame(14'h3003, bm[0], dm[0], 11, 0, 0, "R9 long frame");
        frame(14'h2468, bm[0], dm[0], 9, 0, 0, "R9 long frame");
        frame(14'h1ACE, bm[0], dm[0], 8, 0, 1, "R11 frame with stray strobe");
      end
    frame(14'h0000, 0, 0, 8, 0, 0, "flush");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule